// File: doc/BRIEF.md
# Time-Code Frame Capture and Field Extractor

This block sits behind a pulse-width bit decoder for a once-per-second radio time code. Each decoded bit arrives with a bit strobe. The block shifts the bit into a 60-bit register from the top end, so after a full minute the oldest bit sits at index 0. When the minute strobe rises, the block copies the whole register into a holding register. That copy stays unchanged until the next minute strobe, so downstream logic sees one consistent frame for a whole minute.

From the held frame the block extracts the minute and hour BCD digits. The tens digits are widened to four bits with leading zeros. It checks even parity separately over the minute group and the hour group. A frame-valid flag is raised only when both parities hold and every digit is a legal BCD value.

The field positions sit a fixed offset above their protocol positions. This offset covers one bit interval of decode lag and one bit interval of minute-strobe lag. The offset is a parameter with a default of 2. Everything runs on the single 100 Hz sampling clock, and both strobes are treated as levels whose rising edges are detected.

Top module: `tc_frame_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following are all cleared at that edge: the shift register, the held frame, the four digits, both parity-error flags and `frame_ok`. After reset, `frame_ok` stays low until the first capture.
- R2: A rising edge of `bit_stb` causes exactly one shift. The edge is the first cycle in which `bit_stb` is seen high after a cycle in which it was low. The shift happens one cycle later and samples `bit_in` in that later cycle. The sampled value enters at index 59 and every other bit moves down by one. A strobe that is held high for many cycles still causes only one shift.
- R3: In the cycle where `min_stb` is first seen high, the holding register (`held_frame`) loads the shift register's current value. The outputs show the new frame from the following cycle. At all other times `held_frame` and the digits are unchanged, including while `min_stb` stays high and while bits keep arriving.
- R4: With offset O (default 2), the fields are read from the held frame as follows. Index 0 of each field is its least significant bit.
  - Minute ones: indices 21+O..24+O.
  - Minute tens: indices 25+O..27+O.
  - Minute parity: index 28+O.
  - Hour ones: indices 29+O..32+O.
  - Hour tens: indices 33+O..34+O.
  - Hour parity: index 35+O.
  - No other held bit affects any digit or flag.
- R5: `min_tens` bit 3 and `hr_tens` bits 3..2 are always zero.
- R6: After a capture, `min_par_err` is high exactly when the held indices 21+O..28+O contain an odd number of ones. `hr_par_err` is high exactly when indices 29+O..35+O contain an odd number of ones.
- R7: `frame_ok` is high exactly when all three of these hold: a capture has happened since reset, neither parity flag is set, and all four digits are 9 or less.
- R8: Changes of `bit_in` outside the shift cycle have no effect on the shifted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 Hz sampling clock |
| rst_n | input | 1 | synchronous active-low reset |
| bit_in | input | 1 | decoded bit value |
| bit_stb | input | 1 | bit strobe, rising edge starts a bit |
| min_stb | input | 1 | minute strobe, rising edge captures the frame |
| min_ones | output | 4 | minute ones digit |
| min_tens | output | 4 | minute tens digit, zero-padded |
| hr_ones | output | 4 | hour ones digit |
| hr_tens | output | 4 | hour tens digit, zero-padded |
| min_par_err | output | 1 | minute group parity odd |
| hr_par_err | output | 1 | hour group parity odd |
| frame_ok | output | 1 | held frame passes parity and BCD checks |
| held_frame | output | 60 | holding register contents |

## Verification
Each frame is preceded by two filler bits. Frames carry several hour and minute values: all zeros, a maximal 59/23, and typical times. They also carry date-region and marker bits that must not leak into the digits. Together these separate wrong field offsets and wrong bit order from correct extraction.

Some frames have a flipped minute or hour parity bit, which shows whether the two parity groups are separated correctly. One frame has an ones digit above 9 with correct parity, which isolates the BCD check from the parity check. A frame sent with long strobes and a toggling `bit_in` distinguishes edge-triggered shifting from level-triggered shifting. Bits sent after a capture, with and without a held minute strobe, show whether the holding register truly stays stable.

// File: rtl/tc_pkg.sv
// Shared constants and types for the time-code frame capture block.
// Assumes the 60-bit frame with minute and hour groups at fixed positions.
package tc_pkg;
    localparam int FRAME_BITS   = 60;
    localparam int MIN_ONES_POS = 21;
    localparam int MIN_TENS_POS = 25;
    localparam int MIN_PAR_POS  = 28;
    localparam int HR_ONES_POS  = 29;
    localparam int HR_TENS_POS  = 33;
    localparam int HR_PAR_POS   = 35;
    localparam int MIN_TENS_W   = MIN_PAR_POS - MIN_TENS_POS;
    localparam int HR_TENS_W    = HR_PAR_POS - HR_TENS_POS;
    localparam int WIN_W        = HR_PAR_POS - MIN_ONES_POS + 1;

    typedef logic [3:0] bcd_t;

    // True when a 4-bit value is a legal decimal digit.
    function automatic logic is_bcd(input bcd_t d);
        return d <= 4'd9;
    endfunction
endpackage

// File: rtl/tc_rise_detect.sv
// Rising-edge detector for a level strobe on the sampling clock.
// Assumes the strobe is already synchronous to clk.
module tc_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Remember the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/tc_shift_reg.sv
// Serial-in shift register; new bits enter at the top index.
// Assumes shift_en is a single-cycle pulse per bit.
module tc_shift_reg #(
    parameter int WIDTH = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    // Shift one bit in from the top on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {bit_in, word[WIDTH-1:1]};
    end

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word)); // R8
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> word[WIDTH-1] == $past(bit_in)); // R2
endmodule

// File: rtl/tc_field_extract.sv
// Decodes minute/hour digits and group parities from a window of the held
// frame. The window starts at the minute-ones position plus the offset.
module tc_field_extract
    import tc_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    input  logic             have_frame,
    output bcd_t             min_ones,
    output bcd_t             min_tens,
    output bcd_t             hr_ones,
    output bcd_t             hr_tens,
    output logic             min_par_err,
    output logic             hr_par_err,
    output logic             frame_ok
);
    localparam int MO = 0;
    localparam int MT = MIN_TENS_POS - MIN_ONES_POS;
    localparam int MP = MIN_PAR_POS  - MIN_ONES_POS;
    localparam int HO = HR_ONES_POS  - MIN_ONES_POS;
    localparam int HT = HR_TENS_POS  - MIN_ONES_POS;
    localparam int HP = HR_PAR_POS   - MIN_ONES_POS;

    logic min_odd, hr_odd, all_bcd;

    // Slice the digits and pad the tens digits with zeros.
    always_comb begin
        min_ones = win[MO +: 4];
        hr_ones  = win[HO +: 4];
        min_tens = bcd_t'({{(4-MIN_TENS_W){1'b0}}, win[MT +: MIN_TENS_W]});
        hr_tens  = bcd_t'({{(4-HR_TENS_W){1'b0}}, win[HT +: HR_TENS_W]});
    end

    // Even-parity check over each group including its parity bit.
    assign min_odd = ^win[MP:MO];
    assign hr_odd  = ^win[HP:HO];
    assign all_bcd = is_bcd(min_ones) & is_bcd(min_tens)
                   & is_bcd(hr_ones) & is_bcd(hr_tens);

    assign min_par_err = have_frame & min_odd;
    assign hr_par_err  = have_frame & hr_odd;
    assign frame_ok    = have_frame & ~min_odd & ~hr_odd & all_bcd;
endmodule

// File: rtl/tc_frame_capture.sv
// Time-code frame capture: shifts decoded bits in on bit-strobe edges,
// holds a frame copy on minute-strobe edges, and extracts checked digits.
// Assumes both strobes are synchronous levels on the 100 Hz clock.
module tc_frame_capture
    import tc_pkg::*;
#(
    parameter int OFFSET = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_in,
    input  logic                  bit_stb,
    input  logic                  min_stb,
    output logic [3:0]            min_ones,
    output logic [3:0]            min_tens,
    output logic [3:0]            hr_ones,
    output logic [3:0]            hr_tens,
    output logic                  min_par_err,
    output logic                  hr_par_err,
    output logic                  frame_ok,
    output logic [FRAME_BITS-1:0] held_frame
);
    localparam int WIN_LO = MIN_ONES_POS + OFFSET;

    logic                  bit_rise, min_cap, shift_en, have_frame;
    logic [FRAME_BITS-1:0] sr_word;

    tc_rise_detect u_bit_edge (.clk(clk), .rst_n(rst_n), .level(bit_stb), .rise(bit_rise));
    tc_rise_detect u_min_edge (.clk(clk), .rst_n(rst_n), .level(min_stb), .rise(min_cap));

    // Delay the shift one cycle after the strobe edge so the bit is settled.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_en <= 1'b0;
        else        shift_en <= bit_rise;
    end

    tc_shift_reg #(.WIDTH(FRAME_BITS)) u_sr (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(bit_in), .word(sr_word)
    );

    // Copy the shift register into the holding register once per minute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_frame <= '0;
            have_frame <= 1'b0;
        end else if (min_cap) begin
            held_frame <= sr_word;
            have_frame <= 1'b1;
        end
    end

    tc_field_extract u_fields (
        .win(held_frame[WIN_LO +: WIN_W]), .have_frame(have_frame),
        .min_ones(min_ones), .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens),
        .min_par_err(min_par_err), .hr_par_err(hr_par_err), .frame_ok(frame_ok)
    );

    AST_ONE_SHIFT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !shift_en); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !min_cap |=> $stable(held_frame)); // R3
    AST_TENS_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
        min_tens[3] == 1'b0 && hr_tens[3:2] == 2'b00); // R5
    AST_OK_NO_PARITY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> !min_par_err && !hr_par_err); // R7
    AST_OK_LEGAL_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> min_ones <= 4'd9 && hr_ones <= 4'd9); // R7
    AST_OK_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !have_frame |-> !frame_ok && !min_par_err && !hr_par_err); // R1
endmodule

// File: tb/tc_frame_capture_bench.sv
module tc_frame_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0, bit_stb = 1'b0, min_stb = 1'b0;
    logic [3:0]  min_ones, min_tens, hr_ones, hr_tens;
    logic        min_par_err, hr_par_err, frame_ok;
    logic [59:0] held_frame;
    logic [59:0] model_sr = '0;
    logic [59:0] exp_hold;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tc_frame_capture u_tc_frame_capture (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb), .min_stb(min_stb),
        .min_ones(min_ones), .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens),
        .min_par_err(min_par_err), .hr_par_err(hr_par_err), .frame_ok(frame_ok),
        .held_frame(held_frame)
    );

    // Vector: [19:16] min ones, [15:12] min tens, [11:8] hr ones, [7:4] hr tens,
    // [3] corrupt minute parity, [2] corrupt hour parity, [1] expected frame_ok.
    localparam logic [19:0] VEC [7] = '{
        20'h7341_2, 20'h0000_2, 20'h9532_2, 20'h5280_8,
        20'h1421_4, 20'hC100_0, 20'h8491_2
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit long_stb);
        bit_in = b; bit_stb = 1'b1;
        @(negedge clk); @(negedge clk);
        model_sr = {b, model_sr[59:1]};
        if (long_stb) begin
            bit_in = ~b;
            repeat (6) @(negedge clk);
        end
        bit_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic capture();
        min_stb = 1'b1;
        @(negedge clk);
        exp_hold = model_sr;
        min_stb = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [59:0] build(input logic [19:0] v, input int k);
        logic [59:0] f = '0;
        f[20]    = 1'b1;
        f[24:21] = v[19:16];
        f[27:25] = v[14:12];
        f[28]    = ^{v[19:16], v[14:12]} ^ v[3];
        f[32:29] = v[11:8];
        f[34:33] = v[5:4];
        f[35]    = ^{v[11:8], v[5:4]} ^ v[2];
        f[57:36] = 22'h2A5C3 ^ 22'(k * 22'h1F1);
        f[5:1]   = 5'(k) ^ 5'h15;
        return f;
    endfunction

    task automatic send_frame(input logic [59:0] f, input bit long_stb);
        send_bit(1'b1, long_stb);
        send_bit(1'b0, long_stb);
        for (int p = 0; p < 58; p++) send_bit(f[p], long_stb);
    endtask

    task automatic check_vec(input logic [19:0] v, input logic [59:0] f, input string tag);
        chk({tag, " R3 held frame"}, 64'(held_frame), 64'({f[57:0], 2'b01}));
        chk({tag, " R4 min ones"}, 64'(min_ones), 64'(v[19:16]));
        chk({tag, " R4 R5 min tens"}, 64'(min_tens), 64'({1'b0, v[14:12]}));
        chk({tag, " R4 hr ones"}, 64'(hr_ones), 64'(v[11:8]));
        chk({tag, " R4 R5 hr tens"}, 64'(hr_tens), 64'({2'b00, v[5:4]}));
        chk({tag, " R6 min parity err"}, 64'(min_par_err), 64'(v[3]));
        chk({tag, " R6 hr parity err"}, 64'(hr_par_err), 64'(v[2]));
        chk({tag, " R7 frame ok"}, 64'(frame_ok), 64'(v[1]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [59:0] f;
        logic [59:0] saved;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 held frame", 64'(held_frame), 64'h0);
        chk("R1 digits", 64'({min_ones, min_tens, hr_ones, hr_tens}), 64'h0);
        chk("R1 flags", 64'({min_par_err, hr_par_err, frame_ok}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 frame_ok before capture", 64'(frame_ok), 64'h0);
        // R7: capture of an all-zero register is a valid 00:00 frame
        capture();
        chk("R7 zero frame ok", 64'(frame_ok), 64'h1);

        // Table walk
        for (int i = 0; i < 7; i++) begin
            f = build(VEC[i], i);
            send_frame(f, 1'b0);
            capture();
            check_vec(VEC[i], f, $sformatf("vec%0d", i));
        end

        // R2 R8: long strobes with bit_in toggled after the shift cycle
        f = build(VEC[0], 9);
        send_frame(f, 1'b1);
        capture();
        check_vec(VEC[0], f, "long strobe R2 R8");

        // R3: bits after capture leave held frame and digits unchanged
        saved = held_frame;
        for (int j = 0; j < 4; j++) send_bit(j[0], 1'b0);
        chk("R3 stable after bits", 64'(held_frame), 64'(saved));
        chk("R3 digits stable", 64'({min_ones, hr_ones}), 64'({VEC[0][19:16], VEC[0][11:8]}));

        // R3: minute strobe held high captures once only
        min_stb = 1'b1;
        @(negedge clk);
        exp_hold = model_sr;
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        chk("R3 single capture while min_stb held", 64'(held_frame), 64'(exp_hold));
        min_stb = 1'b0;
        @(negedge clk);
        capture();
        chk("R2 R3 model shift register", 64'(held_frame), 64'(exp_hold));

        // R1: reset mid-operation clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears held", 64'(held_frame), 64'h0);
        chk("R1 reset clears ok", 64'(frame_ok), 64'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule